// File: doc/BRIEF.md
# Clock Control Register with Guarded Writes

This block is the 32-bit control register at the heart of a small clock controller. It keeps the enable bits for an internal multi-speed oscillator, an internal high-speed oscillator, an external high-speed oscillator, the main PLL and a clock security detector. It also keeps a selector for the external oscillator prescaler and a selector for a shared package pin. The ready flags of the oscillators and the PLL lock come in as live status inputs and appear in the register image. The control fields are driven out to the oscillator, PLL and clock-mux logic, which are not part of this block.

Software writes arrive on a zero-wait-state port with one strobe per byte lane. Each write is filtered by the state of the hardware. The pin-function selector is frozen while the external oscillator is enabled or ready. The PLL enable cannot be cleared while the PLL drives the system clock, and a low-power entry request clears it. The security enable can only be set by software. A small detector watches a clock-failure input through a synchronizer. It raises a sticky failure flag and then disarms itself.

Top module: `clkctl_reg`

## Requirements
- R1: After reset `rdata` reads 0x0000_0061 when all status inputs are 0. That value means multi-speed oscillator enable (bit 0) = 1 and range field (bits 7:4) = 6, with every other stored field 0. `css_armed` and `css_fail` are 0 after reset.
- R2: A write is a cycle with `sel` and `wr_en` both high. It updates only the writable bits inside the byte lanes whose `be` bit is set: `be[n]` covers bits 8n+7:8n. The new value shows on `rdata` in the cycle after the clock edge.
- R3: The read-only bits follow their inputs in the same cycle, and writes never change them: bit 1 = `msi_rdy`, bit 10 = `hsi_rdy`, bit 17 = `hse_rdy`, bit 25 = `pll_lock`.
- R4: Bits 31:26, 23:22, 18, 15:11, 9 and 3:2 always read 0, and writes to them have no effect.
- R5: Bit 24 is the PLL enable. A write of 0 to it is ignored while `pll_is_sysclk` is 1.
- R6: When `lowpower_req` is high at a clock edge, the PLL enable is 0 after that edge. This holds even if a write of 1 to bit 24 happens in the same cycle.
- R7: Bit 21, the pin-function selector, changes on a write only when bit 16 (external oscillator enable) and `hse_rdy` are both 0 at that edge.
- R8: Bit 20 is a plain read/write prescaler select. Its value drives `hse_div2`: 1 means divide by two.
- R9: Bit 19, the security enable, is set by a write of 1. Writes of 0 leave it unchanged, and only reset clears it.
- R10: `css_armed` is 1 exactly when bit 19 is 1, `hse_rdy` is 1 and `css_fail` is 0.
- R11: `clk_fail` passes through SYNC_STAGES flip-flops. The synchronized failure sets `css_fail` on the next edge only while `css_armed` is 1. `css_fail` then stays 1 until reset, and a failure while disarmed is ignored.
- R12: The outputs `msi_en`, `msi_range`, `hsi_en`, `hse_en`, `supply_sel` and `pll_en` equal bits 0, 7:4, 8, 16, 21 and 24 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Register selected |
| wr_en | input | 1 | Write request |
| be | input | 4 | Byte-lane write strobes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Register image |
| msi_rdy | input | 1 | Multi-speed oscillator ready |
| hsi_rdy | input | 1 | Internal high-speed oscillator ready |
| hse_rdy | input | 1 | External oscillator ready |
| pll_lock | input | 1 | PLL locked |
| pll_is_sysclk | input | 1 | PLL currently drives the system clock |
| lowpower_req | input | 1 | Low-power mode entry request |
| clk_fail | input | 1 | Raw external clock failure indication |
| msi_en | output | 1 | Multi-speed oscillator enable |
| msi_range | output | 4 | Multi-speed oscillator range |
| hsi_en | output | 1 | Internal high-speed oscillator enable |
| hse_en | output | 1 | External oscillator enable |
| hse_div2 | output | 1 | Divide external clock by two |
| supply_sel | output | 1 | Shared pin: 0 general purpose, 1 oscillator supply |
| pll_en | output | 1 | PLL enable |
| css_armed | output | 1 | Failure detector armed |
| css_fail | output | 1 | Sticky clock-failure flag |

## Verification
The bench builds the block with its defaults: two synchronizer stages, multi-speed enable set at reset, and reset range 6. These give the 0x61 reset image and a failure latency of exactly three edges, so the bench can sample `css_fail` both one edge before and on the edge it rises. It also exercises the guard conditions against live inputs. Examples are a write of 0 to the pin selector with the oscillator ready, and a PLL write that coincides with a low-power request.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

   localparam int unsigned REG_W = 32;
   localparam int unsigned NLANE = REG_W / 8;

   localparam int unsigned B_MSI_ON   = 0;
   localparam int unsigned B_MSI_RDY  = 1;
   localparam int unsigned B_MSI_RNG  = 4;
   localparam int unsigned B_HSI_ON   = 8;
   localparam int unsigned B_HSI_RDY  = 10;
   localparam int unsigned B_HSE_ON   = 16;
   localparam int unsigned B_HSE_RDY  = 17;
   localparam int unsigned B_CSS_EN   = 19;
   localparam int unsigned B_HSE_DIV  = 20;
   localparam int unsigned B_SUP_SEL  = 21;
   localparam int unsigned B_PLL_ON   = 24;
   localparam int unsigned B_PLL_RDY  = 25;

   localparam logic [REG_W-1:0] RES_MASK = 32'hFCC4_FA0C;

   typedef struct packed {
      logic       pll_on;
      logic       sup_sel;
      logic       hse_div;
      logic       css_en;
      logic       hse_on;
      logic       hsi_on;
      logic [3:0] msi_range;
      logic       msi_on;
   } ctl_t;

endpackage

// File: rtl/clkctl_strobe_expand.sv
module clkctl_strobe_expand #(
   parameter int unsigned LANES = 4
) (
   input  logic [LANES-1:0]   be,
   output logic [8*LANES-1:0] bit_mask
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign bit_mask[8*g +: 8] = {8{be[g]}};
   end

endmodule

// File: rtl/clkctl_next.sv
module clkctl_next
   import clkctl_pkg::*;
(
   input  ctl_t             cur,
   input  logic [REG_W-1:0] wmask,
   input  logic [REG_W-1:0] wdata,
   input  logic             pll_is_sysclk,
   input  logic             hse_rdy,
   input  logic             lowpower_req,
   output ctl_t             nxt
);

   logic sup_open;
   logic pll_wr_ok;
   logic unused_bits;

   // selector may move only while the external oscillator is fully off
   assign sup_open  = !cur.hse_on && !hse_rdy;
   // a clear of the PLL enable is refused while the PLL is the system clock
   assign pll_wr_ok = wdata[B_PLL_ON] || !pll_is_sysclk;

   always_comb begin
      nxt = cur;
      if (wmask[B_MSI_ON]) nxt.msi_on = wdata[B_MSI_ON];
      for (int i = 0; i < 4; i++) begin
         if (wmask[B_MSI_RNG+i]) nxt.msi_range[i] = wdata[B_MSI_RNG+i];
      end
      if (wmask[B_HSI_ON])  nxt.hsi_on  = wdata[B_HSI_ON];
      if (wmask[B_HSE_ON])  nxt.hse_on  = wdata[B_HSE_ON];
      if (wmask[B_HSE_DIV]) nxt.hse_div = wdata[B_HSE_DIV];
      if (wmask[B_SUP_SEL] && sup_open) nxt.sup_sel = wdata[B_SUP_SEL];
      nxt.css_en = cur.css_en | (wmask[B_CSS_EN] & wdata[B_CSS_EN]);
      if (lowpower_req) begin
         nxt.pll_on = 1'b0;
      end else if (wmask[B_PLL_ON] && pll_wr_ok) begin
         nxt.pll_on = wdata[B_PLL_ON];
      end
   end

   assign unused_bits = ^{wmask[31:25], wmask[23:22], wmask[18:17], wmask[15:9], wmask[3:1],
                          wdata[31:25], wdata[23:22], wdata[18:17], wdata[15:9], wdata[3:1]};

endmodule

// File: rtl/clkctl_css.sv
module clkctl_css #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic css_en,
   input  logic hse_rdy,
   input  logic fail_in,
   output logic armed,
   output logic fail_flag
);

   logic fail_s;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign fail_s = fail_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '0;
         end else begin
            chain[0] <= fail_in;
            for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign fail_s = chain[SYNC_STAGES-1];
   end

   assign armed = css_en && hse_rdy && !fail_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                fail_flag <= 1'b0;
      else if (armed && fail_s)  fail_flag <= 1'b1;
   end

endmodule

// File: rtl/clkctl_reg.sv
module clkctl_reg
   import clkctl_pkg::*;
#(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          MSI_ON_RST    = 1'b1,
   parameter logic [3:0]  MSI_RANGE_RST = 4'd6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             wr_en,
   input  logic [NLANE-1:0] be,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   input  logic             msi_rdy,
   input  logic             hsi_rdy,
   input  logic             hse_rdy,
   input  logic             pll_lock,
   input  logic             pll_is_sysclk,
   input  logic             lowpower_req,
   input  logic             clk_fail,
   output logic             msi_en,
   output logic [3:0]       msi_range,
   output logic             hsi_en,
   output logic             hse_en,
   output logic             hse_div2,
   output logic             supply_sel,
   output logic             pll_en,
   output logic             css_armed,
   output logic             css_fail
);

   localparam ctl_t RST_CTL = '{pll_on: 1'b0, sup_sel: 1'b0, hse_div: 1'b0, css_en: 1'b0,
                                hse_on: 1'b0, hsi_on: 1'b0, msi_range: MSI_RANGE_RST,
                                msi_on: MSI_ON_RST};

   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("clkctl_reg: SYNC_STAGES must be 0 to 4");
   end
   if (NLANE * 8 != REG_W) begin : g_bad_width
      $error("clkctl_reg: register width must be whole bytes");
   end

   ctl_t             cur;
   ctl_t             nxt;
   logic [REG_W-1:0] lane_mask;
   logic [REG_W-1:0] wmask;

   clkctl_strobe_expand #(.LANES(NLANE)) u_exp (
      .be       (be),
      .bit_mask (lane_mask)
   );

   assign wmask = (sel && wr_en) ? lane_mask : '0;

   clkctl_next u_nxt (
      .cur           (cur),
      .wmask         (wmask),
      .wdata         (wdata),
      .pll_is_sysclk (pll_is_sysclk),
      .hse_rdy       (hse_rdy),
      .lowpower_req  (lowpower_req),
      .nxt           (nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur <= RST_CTL;
      else        cur <= nxt;
   end

   clkctl_css #(.SYNC_STAGES(SYNC_STAGES)) u_css (
      .clk       (clk),
      .rst_n     (rst_n),
      .css_en    (cur.css_en),
      .hse_rdy   (hse_rdy),
      .fail_in   (clk_fail),
      .armed     (css_armed),
      .fail_flag (css_fail)
   );

   always_comb begin
      rdata                  = '0;
      rdata[B_MSI_ON]        = cur.msi_on;
      rdata[B_MSI_RDY]       = msi_rdy;
      rdata[B_MSI_RNG +: 4]  = cur.msi_range;
      rdata[B_HSI_ON]        = cur.hsi_on;
      rdata[B_HSI_RDY]       = hsi_rdy;
      rdata[B_HSE_ON]        = cur.hse_on;
      rdata[B_HSE_RDY]       = hse_rdy;
      rdata[B_CSS_EN]        = cur.css_en;
      rdata[B_HSE_DIV]       = cur.hse_div;
      rdata[B_SUP_SEL]       = cur.sup_sel;
      rdata[B_PLL_ON]        = cur.pll_on;
      rdata[B_PLL_RDY]       = pll_lock;
   end

   assign msi_en     = cur.msi_on;
   assign msi_range  = cur.msi_range;
   assign hsi_en     = cur.hsi_on;
   assign hse_en     = cur.hse_on;
   assign hse_div2   = cur.hse_div;
   assign supply_sel = cur.sup_sel;
   assign pll_en     = cur.pll_on;

endmodule

// File: rtl/clkctl_reg_chk.sv
module clkctl_reg_chk
   import clkctl_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic [REG_W-1:0] rdata,
   input logic             pll_en,
   input logic             pll_is_sysclk,
   input logic             lowpower_req,
   input logic             hse_en,
   input logic             hse_rdy,
   input logic             supply_sel,
   input logic             css_armed,
   input logic             css_fail,
   input logic             pll_lock
);

   a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata & RES_MASK) == '0);

   a_r3_lock_visible: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[B_PLL_RDY] == pll_lock);

   a_r5_pll_held: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_en && pll_is_sysclk && !lowpower_req) |=> pll_en);

   a_r6_lowpower_clear: assert property (@(posedge clk) disable iff (!rst_n)
      lowpower_req |=> !pll_en);

   a_r7_selector_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (hse_en || hse_rdy) |=> $stable(supply_sel));

   a_r9_css_set_only: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[B_CSS_EN] |=> rdata[B_CSS_EN]);

   a_r10_disarm_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (!hse_rdy || css_fail) |-> !css_armed);

   a_r11_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      css_fail |=> css_fail);

endmodule

bind clkctl_reg clkctl_reg_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rdata         (rdata),
   .pll_en        (pll_en),
   .pll_is_sysclk (pll_is_sysclk),
   .lowpower_req  (lowpower_req),
   .hse_en        (hse_en),
   .hse_rdy       (hse_rdy),
   .supply_sel    (supply_sel),
   .css_armed     (css_armed),
   .css_fail      (css_fail),
   .pll_lock      (pll_lock)
);

// File: tb/sim_clkctl_reg.sv
module sim_clkctl_reg;

   localparam int CLK_P = 10;
   localparam int NVEC  = 8;

   // {be, wdata, expected rdata}, applied in order from the reset state
   localparam logic [67:0] VT [NVEC] = '{
      {4'hF, 32'hFFFF_FFFF, 32'h0139_01F1},
      {4'h1, 32'h0000_0000, 32'h0139_0100},
      {4'h4, 32'h0000_0000, 32'h0128_0100},
      {4'h4, 32'h0000_0000, 32'h0108_0100},
      {4'h8, 32'h0000_0000, 32'h0008_0100},
      {4'h2, 32'h0000_0000, 32'h0008_0000},
      {4'h1, 32'h0000_0035, 32'h0008_0031},
      {4'hE, 32'h0130_0000, 32'h0138_0031}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, wr_en = 1'b0;
   logic [3:0]  be = 4'h0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        msi_rdy = 1'b0, hsi_rdy = 1'b0, hse_rdy = 1'b0, pll_lock = 1'b0;
   logic        pll_is_sysclk = 1'b0, lowpower_req = 1'b0, clk_fail = 1'b0;
   logic        msi_en, hsi_en, hse_en, hse_div2, supply_sel, pll_en, css_armed, css_fail;
   logic [3:0]  msi_range;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   clkctl_reg u0 (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .be(be), .wdata(wdata),
      .rdata(rdata), .msi_rdy(msi_rdy), .hsi_rdy(hsi_rdy), .hse_rdy(hse_rdy),
      .pll_lock(pll_lock), .pll_is_sysclk(pll_is_sysclk), .lowpower_req(lowpower_req),
      .clk_fail(clk_fail), .msi_en(msi_en), .msi_range(msi_range), .hsi_en(hsi_en),
      .hse_en(hse_en), .hse_div2(hse_div2), .supply_sel(supply_sel), .pll_en(pll_en),
      .css_armed(css_armed), .css_fail(css_fail)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [3:0] b, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr_en = 1'b1; be = b; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr_en = 1'b0; be = 4'h0; wdata = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset image", rdata, 32'h0000_0061);
      check("R1 reset flags", {30'd0, css_armed, css_fail}, 32'd0);
      check("R12 reset msi outputs", {27'd0, msi_range, msi_en}, {27'd0, 4'd6, 1'b1});

      // vector table: R2 lanes, R4 reserved, R7 guard by enable, R8, R9
      for (int i = 0; i < NVEC; i++) begin
         do_write(VT[i][67:64], VT[i][63:32]);
         check($sformatf("R2 R4 R7 R9 vector %0d", i), rdata, VT[i][31:0]);
      end
      check("R12 control outputs",
            {24'd0, pll_en, supply_sel, hse_div2, hse_en, hsi_en, msi_en, 2'd0},
            {24'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0});
      check("R12 msi range", {28'd0, msi_range}, 32'd3);
      check("R8 divider output", {31'd0, hse_div2}, 32'd1);

      // R3 live ready flags; R7 guard by ready input
      @(negedge clk);
      msi_rdy = 1'b1; hsi_rdy = 1'b1; hse_rdy = 1'b1; pll_lock = 1'b1;
      #1 check("R3 ready flags visible", rdata, 32'h033A_0433);
      do_write(4'hF, 32'h0000_0000);
      check("R3 R7 ready bits kept, selector frozen", rdata, 32'h022A_0402);

      // R10 arming
      check("R10 armed when enabled and ready", {31'd0, css_armed}, 32'd1);
      @(negedge clk);
      hse_rdy = 1'b0;
      #1 check("R10 disarmed when not ready", {31'd0, css_armed}, 32'd0);

      // R11 failure while disarmed is ignored
      clk_fail = 1'b1;
      repeat (4) @(negedge clk);
      clk_fail = 1'b0;
      repeat (3) @(negedge clk);
      check("R11 failure ignored when disarmed", {31'd0, css_fail}, 32'd0);

      // R11 synchronized failure latency and stickiness
      hse_rdy = 1'b1;
      clk_fail = 1'b1;
      @(negedge clk);
      check("R11 no flag after first edge", {31'd0, css_fail}, 32'd0);
      @(negedge clk);
      check("R11 no flag after second edge", {31'd0, css_fail}, 32'd0);
      @(negedge clk);
      check("R11 flag after third edge", {31'd0, css_fail}, 32'd1);
      check("R10 disarmed after failure", {31'd0, css_armed}, 32'd0);
      clk_fail = 1'b0;
      repeat (3) @(negedge clk);
      check("R11 flag sticky", {31'd0, css_fail}, 32'd1);

      // R5 clear refused while PLL is system clock
      do_write(4'h8, 32'h0100_0000);
      check("R5 pll set", {31'd0, pll_en}, 32'd1);
      pll_is_sysclk = 1'b1;
      do_write(4'h8, 32'h0000_0000);
      check("R5 clear ignored while system clock", {31'd0, pll_en}, 32'd1);
      pll_is_sysclk = 1'b0;
      do_write(4'h8, 32'h0000_0000);
      check("R5 clear accepted otherwise", {31'd0, pll_en}, 32'd0);

      // R6 low-power entry beats a simultaneous write of 1
      do_write(4'h8, 32'h0100_0000);
      @(negedge clk);
      sel = 1'b1; wr_en = 1'b1; be = 4'h8; wdata = 32'h0100_0000; lowpower_req = 1'b1;
      pll_is_sysclk = 1'b1;
      @(negedge clk);
      sel = 1'b0; wr_en = 1'b0; be = 4'h0; wdata = '0; lowpower_req = 1'b0;
      check("R6 low-power over write", {31'd0, pll_en}, 32'd0);
      do_write(4'h8, 32'h0100_0000);
      @(negedge clk);
      lowpower_req = 1'b1;
      @(negedge clk);
      lowpower_req = 1'b0;
      pll_is_sysclk = 1'b0;
      check("R6 low-power alone clears", {31'd0, pll_en}, 32'd0);

      // reset clears sticky state
      msi_rdy = 1'b0; hsi_rdy = 1'b0; hse_rdy = 1'b0; pll_lock = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 R9 image after second reset", rdata, 32'h0000_0061);
      check("R11 flag cleared by reset", {31'd0, css_fail}, 32'd0);

      // R9 set-only
      do_write(4'h4, 32'h0008_0000);
      check("R9 security enable set", rdata, 32'h0008_0061);
      do_write(4'h4, 32'h0000_0000);
      check("R9 write of 0 ignored", rdata, 32'h0008_0061);

      // R7 guard by enable bit, R8 divider
      do_write(4'h4, 32'h0001_0000);
      check("R7 oscillator enabled", rdata, 32'h0009_0061);
      do_write(4'h4, 32'h0021_0000);
      check("R7 selector write blocked", rdata, 32'h0009_0061);
      do_write(4'h4, 32'h0011_0000);
      check("R8 divider set", rdata, 32'h0019_0061);
      check("R8 divider output set", {31'd0, hse_div2}, 32'd1);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule